// File: doc/BRIEF.md
# Dual-Mode Incremental Step Pulse Program Sequencer

This block is the control state machine that writes one page of two-bit-per-cell flash by incremental step pulse programming. Every cell starts erased at the lowest threshold level, L0. Each cell has a target level from L0 to L3. All targets are driven in one full-sequence pass. Each loop of the sequence does three things in order. It fires one gate pulse with the program and inhibit charge pumps enabled. It leaves one idle cycle. It then runs verify reads with only the verify pump enabled. A cell that passes the final verify level of its own target is inhibited from every later pulse. The gate step code starts at 0, which stands for 14 V, and rises by one code (250 mV) per loop. Code 20 is the last pulse, at 19 V.

A mode bit chooses between single-verify and double-verify operation. The pump hardware is the same in both modes; only the enable sequence differs. In double-verify mode, each final verify is preceded by a pre-verify at a slightly lower level. A cell that passes its pre-verify gets reduced bitline bias on the pulses that follow, which roughly halves its step. This tightens the final threshold placement, at the cost of longer loops. The number of pulses used stays readable after the operation, so the time cost of double-verify mode can be measured.

Top module: `pgm_seq`

## Requirements
- R1: After reset the block is idle. All pump enables, `busy`, `done` and `fail` are low, `pulse_cnt` is 0 and `inhibit` is all zero.
- R2: Cell i takes its target from `tgt[2i+1:2i]`: 0 is L0, and 1, 2 and 3 are L1, L2 and L3. A cell that targets L0 is inhibited as soon as `start` is accepted, and it is never pulsed.
- R3: Each loop runs in this order. First comes one cycle with `pgm_pump_en` and `inh_pump_en` high. Next comes one cycle with every pump enable low. Then come verify cycles, in which only `vfy_pump_en` is high.
- R4: In single-verify mode (`dv_mode`=0), each loop does three final verify cycles with `vfy_lvl` = 1, 2 and then 3. `pre_vfy` stays low throughout.
- R5: In double-verify mode (`dv_mode`=1), each level is checked twice: first a pre-verify cycle (`pre_vfy`=1), then a final verify cycle at the same `vfy_lvl`. That gives six verify cycles per loop.
- R6: `step_code` is 0 at the first pulse of an operation and rises by exactly one for each later pulse. It never exceeds 20.
- R7: A cell is inhibited when `vfy_pass` for that cell is high in a final verify cycle whose `vfy_lvl` equals its target. It then stays inhibited until the next accepted `start`. An inhibited cell takes no further pulses.
- R8: In double-verify mode, a cell whose pre-verify at its own target level passes shows in `bias_mask` from the next cycle until it is inhibited. In single-verify mode, `bias_mask` stays zero.
- R9: When every cell is inhibited after a loop's verifies, the operation ends with `done` high. If every target is L0, `done` rises one cycle after `start` and no pulse is issued. `done` holds until the next accepted `start`.
- R10: If cells are still uninhibited after the loop whose pulse used step code 20, the operation ends with `fail` high. `fail` holds until the next accepted `start`.
- R11: `pulse_cnt` equals the number of program pulses issued in the last operation, and it holds that value while idle.
- R12: `dv_mode` and `tgt` are captured when `start` is accepted in the idle state. Changes to them, and further `start` pulses, while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin programming one page (accepted only while idle) |
| dv_mode | input | 1 | 1 selects double-verify, 0 selects single-verify |
| tgt | input | 2*NCELL | Target level of each cell, two bits per cell |
| vfy_pass | input | NCELL | Per-cell sense result of the current verify read |
| pgm_pump_en | output | 1 | Program charge pump enable |
| inh_pump_en | output | 1 | Inhibit charge pump enable |
| vfy_pump_en | output | 1 | Verify charge pump enable |
| pre_vfy | output | 1 | Current verify read uses the lower pre-verify level |
| vfy_lvl | output | 2 | Level under verify (1..3), 0 when not verifying |
| step_code | output | 5 | Gate voltage step code, 0..20 |
| inhibit | output | NCELL | Cells excluded from further pulses |
| bias_mask | output | NCELL | Cells receiving reduced bitline bias on the next pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed with all cells placed |
| fail | output | 1 | Last operation ran out of steps |
| pulse_cnt | output | 5 | Pulses issued in the last operation |

## Verification
The bench attaches a behavioural cell model. Each cell has its own speed, its threshold climbs by that speed on every uninhibited pulse, and it climbs by half that speed while it is biased. The first pattern places a single cell at every target level under four speeds, in both modes. These runs separate the two modes by final threshold and pulse count, and they show whether the matching between target and verify level is right. A mixed page with all four targets tests the per-cell inhibit timing while cells finish on different loops. A page that is all L0 covers the case with no pulses. A slow cell exhausts the 21 steps and reaches the fail path. A final run changes the mode and targets and pulses `start` in the middle of an operation, to show that the captured configuration is kept.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_PRE,
        ST_FIN,
        ST_EVAL
    } seq_state_t;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_TOP = 2'd3;
endpackage

// File: rtl/pgm_seq_cells.sv
module pgm_seq_cells
    import pgm_seq_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [2*NCELL-1:0] tgt_in,
    input  logic               vfy_on,
    input  logic               pre_on,
    input  lvl_t               lvl,
    input  logic [NCELL-1:0]   pass,
    output logic [NCELL-1:0]   inhibit,
    output logic [NCELL-1:0]   bias_mask,
    output logic               all_inh,
    output logic               none_tgt
);
    logic [NCELL-1:0] bias_q;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        lvl_t tgt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tgt_q      <= '0;
                inhibit[i] <= 1'b0;
                bias_q[i]  <= 1'b0;
            end else if (clr) begin
                tgt_q      <= tgt_in[2*i +: 2];
                inhibit[i] <= (tgt_in[2*i +: 2] == 2'd0);
                bias_q[i]  <= 1'b0;
            end else if (vfy_on && pass[i] && tgt_q == lvl) begin
                if (pre_on) bias_q[i]  <= 1'b1;
                else        inhibit[i] <= 1'b1;
            end
        end
    end

    assign bias_mask = bias_q & ~inhibit;
    assign all_inh   = &inhibit;
    assign none_tgt  = ~|tgt_in;
endmodule

// File: rtl/pgm_seq_step.sv
module pgm_seq_step #(
    parameter int STEP_MAX = 20,
    parameter int STEP_W   = 5,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              pulse_on,
    output logic [STEP_W-1:0] step_code,
    output logic [CNT_W-1:0]  pulse_cnt,
    output logic              at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_code <= '0;
            pulse_cnt <= '0;
        end else if (clr) begin
            step_code <= '0;
            pulse_cnt <= '0;
        end else begin
            if (inc)      step_code <= step_code + 1'b1;
            if (pulse_on) pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    assign at_max = (step_code == STEP_W'(STEP_MAX));
endmodule

// File: rtl/pgm_seq_ctrl.sv
module pgm_seq_ctrl
    import pgm_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dv_mode,
    input  logic none_tgt,
    input  logic all_inh,
    input  logic at_max,
    output logic clr,
    output logic step_inc,
    output logic pulse_on,
    output logic vfy_on,
    output logic pre_on,
    output lvl_t lvl,
    output logic busy,
    output logic done,
    output logic fail
);
    seq_state_t st, st_nx;
    logic       dv_q;
    lvl_t       lvl_q;
    logic       accept;

    assign accept = start && (st == ST_IDLE);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (accept && !none_tgt) st_nx = ST_PULSE;
            ST_PULSE: st_nx = ST_GAP;
            ST_GAP:   st_nx = dv_q ? ST_PRE : ST_FIN;
            ST_PRE:   st_nx = ST_FIN;
            ST_FIN:   begin
                if (lvl_q == LVL_TOP) st_nx = ST_EVAL;
                else                  st_nx = dv_q ? ST_PRE : ST_FIN;
            end
            ST_EVAL:  st_nx = (all_inh || at_max) ? ST_IDLE : ST_PULSE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q  <= 1'b0;
            lvl_q <= 2'd1;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            if (accept) begin
                dv_q <= dv_mode;
                done <= none_tgt;
                fail <= 1'b0;
            end
            if (st == ST_GAP)
                lvl_q <= 2'd1;
            else if (st == ST_FIN && lvl_q != LVL_TOP)
                lvl_q <= lvl_q + 2'd1;
            if (st == ST_EVAL) begin
                if (all_inh)     done <= 1'b1;
                else if (at_max) fail <= 1'b1;
            end
        end
    end

    always_comb begin
        clr      = accept;
        pulse_on = (st == ST_PULSE);
        pre_on   = (st == ST_PRE);
        vfy_on   = (st == ST_PRE) || (st == ST_FIN);
        lvl      = vfy_on ? lvl_q : 2'd0;
        step_inc = (st == ST_EVAL) && !all_inh && !at_max;
        busy     = (st != ST_IDLE);
    end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
    import pgm_seq_pkg::*;
#(
    parameter  int NCELL    = 8,
    parameter  int STEP_MAX = 20,
    localparam int STEP_W   = $clog2(STEP_MAX + 1),
    localparam int CNT_W    = $clog2(STEP_MAX + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dv_mode,
    input  logic [2*NCELL-1:0] tgt,
    input  logic [NCELL-1:0]   vfy_pass,
    output logic               pgm_pump_en,
    output logic               inh_pump_en,
    output logic               vfy_pump_en,
    output logic               pre_vfy,
    output logic [1:0]         vfy_lvl,
    output logic [STEP_W-1:0]  step_code,
    output logic [NCELL-1:0]   inhibit,
    output logic [NCELL-1:0]   bias_mask,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [CNT_W-1:0]   pulse_cnt
);
    logic clr, step_inc, pulse_on, all_inh, none_tgt, at_max;

    pgm_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dv_mode  (dv_mode),
        .none_tgt (none_tgt),
        .all_inh  (all_inh),
        .at_max   (at_max),
        .clr      (clr),
        .step_inc (step_inc),
        .pulse_on (pulse_on),
        .vfy_on   (vfy_pump_en),
        .pre_on   (pre_vfy),
        .lvl      (vfy_lvl),
        .busy     (busy),
        .done     (done),
        .fail     (fail)
    );

    pgm_seq_cells #(.NCELL(NCELL)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .tgt_in    (tgt),
        .vfy_on    (vfy_pump_en),
        .pre_on    (pre_vfy),
        .lvl       (vfy_lvl),
        .pass      (vfy_pass),
        .inhibit   (inhibit),
        .bias_mask (bias_mask),
        .all_inh   (all_inh),
        .none_tgt  (none_tgt)
    );

    pgm_seq_step #(.STEP_MAX(STEP_MAX), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .inc       (step_inc),
        .pulse_on  (pulse_on),
        .step_code (step_code),
        .pulse_cnt (pulse_cnt),
        .at_max    (at_max)
    );

    assign pgm_pump_en = pulse_on;
    assign inh_pump_en = pulse_on;
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
    parameter  int NCELL    = 8,
    parameter  int STEP_MAX = 20,
    localparam int STEP_W   = $clog2(STEP_MAX + 1),
    localparam int CNT_W    = $clog2(STEP_MAX + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               dv_mode,
    input logic [2*NCELL-1:0] tgt,
    input logic [NCELL-1:0]   vfy_pass,
    input logic               pgm_pump_en,
    input logic               inh_pump_en,
    input logic               vfy_pump_en,
    input logic               pre_vfy,
    input logic [1:0]         vfy_lvl,
    input logic [STEP_W-1:0]  step_code,
    input logic [NCELL-1:0]   inhibit,
    input logic [NCELL-1:0]   bias_mask,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic [CNT_W-1:0]   pulse_cnt
);
    // R3
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vfy_pump_en |-> (!pgm_pump_en && !inh_pump_en));

    // R3
    gap_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_pump_en |=> (!pgm_pump_en && !inh_pump_en && !vfy_pump_en));

    // R5
    pre_then_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_vfy |=> (vfy_pump_en && !pre_vfy && vfy_lvl == $past(vfy_lvl)));

    // R6
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_code <= STEP_W'(STEP_MAX));

    // R6
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_code) |-> (step_code == '0 || step_code == $past(step_code) + 1'b1));

    // R7
    inh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((inhibit & $past(inhibit)) == $past(inhibit)));

    // R8
    bias_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bias_mask & ~$past(bias_mask)) != '0) |-> $past(pre_vfy));

    // R9
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R11
    fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !busy) |-> (pulse_cnt == CNT_W'(STEP_MAX + 1)));
endmodule

bind pgm_seq pgm_seq_chk #(.NCELL(NCELL), .STEP_MAX(STEP_MAX)) u_chk (.*);

// File: tb/pgm_seq_tb.sv
`timescale 1ns/1ps
module pgm_seq_tb;
    localparam int N = 8;
    localparam int PMAX = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dv_mode = 1'b0;
    logic [2*N-1:0] tgt = '0;
    logic [N-1:0] vfy_pass;
    logic pgm_pump_en, inh_pump_en, vfy_pump_en, pre_vfy, busy, done, fail;
    logic [1:0] vfy_lvl;
    logic [4:0] step_code, pulse_cnt;
    logic [N-1:0] inhibit, bias_mask;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int spd [N];
    int vt [N];
    logic [2*N-1:0] tgt_run = '0;
    logic model_clr = 1'b0;
    bit run_dv = 1'b0;
    int pulses_seen, vfy_seen, pre_seen, step_err, seq_err, bias_err;
    logic prev_pgm;

    always #2.5 clk = ~clk;

    pgm_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dv_mode(dv_mode), .tgt(tgt),
        .vfy_pass(vfy_pass), .pgm_pump_en(pgm_pump_en), .inh_pump_en(inh_pump_en),
        .vfy_pump_en(vfy_pump_en), .pre_vfy(pre_vfy), .vfy_lvl(vfy_lvl),
        .step_code(step_code), .inhibit(inhibit), .bias_mask(bias_mask),
        .busy(busy), .done(done), .fail(fail), .pulse_cnt(pulse_cnt)
    );

    always_comb begin
        for (int i = 0; i < N; i++)
            vfy_pass[i] = (vfy_lvl != 2'd0) &&
                          (vt[i] >= 40 * int'(vfy_lvl) - (pre_vfy ? 8 : 0));
    end

    always @(negedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < N; i++) vt[i] <= 0;
            pulses_seen <= 0; vfy_seen <= 0; pre_seen <= 0;
            step_err <= 0; seq_err <= 0; bias_err <= 0; prev_pgm <= 1'b0;
        end else begin
            if (pgm_pump_en) begin
                for (int i = 0; i < N; i++)
                    if (!inhibit[i] && tgt_run[2*i +: 2] != 2'd0)
                        vt[i] <= vt[i] + (bias_mask[i] ? spd[i] / 2 : spd[i]);
                if (int'(step_code) != pulses_seen) step_err <= step_err + 1;
                pulses_seen <= pulses_seen + 1;
            end
            if (vfy_pump_en) vfy_seen <= vfy_seen + 1;
            if (pre_vfy) pre_seen <= pre_seen + 1;
            if ((pgm_pump_en != inh_pump_en) || (vfy_pump_en && pgm_pump_en) ||
                (prev_pgm && (pgm_pump_en || vfy_pump_en || inh_pump_en)))
                seq_err <= seq_err + 1;
            if (!run_dv && bias_mask != '0) bias_err <= bias_err + 1;
            prev_pgm <= pgm_pump_en;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Ideal per-cell result: pulses needed (99 if never) and final threshold.
    task automatic expect_cell(input int s, input int lv, input bit dv,
                               output int n, output int v);
        int f, p;
        bit b;
        n = 0; v = 0;
        if (lv != 0) begin
            f = 40 * lv; p = f - 8; b = 1'b0; n = 99;
            for (int k = 1; k <= PMAX; k++) begin
                if (n == 99) begin
                    v += b ? s / 2 : s;
                    if (v >= f) n = k;
                    else if (dv && v >= p) b = 1'b1;
                end
            end
        end
    endtask

    task automatic run(input bit dv, input bit disturb);
        int n, v, maxn, lv;
        bit fexp;
        run_dv = dv;
        model_clr = 1'b1;
        tgt = tgt_run;
        dv_mode = dv;
        @(negedge clk);
        model_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (10) @(negedge clk);
            dv_mode = !dv;
            tgt = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        maxn = 0;
        fexp = 1'b0;
        for (int i = 0; i < N; i++) begin
            lv = int'(tgt_run[2*i +: 2]);
            expect_cell(spd[i], lv, dv, n, v);
            if (n > PMAX) begin
                fexp = 1'b1;
                maxn = PMAX;
            end else if (n > maxn) maxn = n;
            if (lv == 0)
                chk(inhibit[i] == 1'b1 && vt[i] == 0, "R2 L0 cell inhibited", vt[i], 0);
            else
                chk(inhibit[i] == (n <= PMAX), "R7 inhibit", int'(inhibit[i]), int'(n <= PMAX));
            chk(vt[i] == v, dv ? "R8 final threshold" : "R7 final threshold", vt[i], v);
        end
        chk(done == !fexp, "R9 done", int'(done), int'(!fexp));
        chk(fail == fexp, "R10 fail", int'(fail), int'(fexp));
        chk(int'(pulse_cnt) == maxn, disturb ? "R12 pulse_cnt" : "R11 pulse_cnt",
            int'(pulse_cnt), maxn);
        chk(pulses_seen == maxn, "R11 pulses seen", pulses_seen, maxn);
        chk(vfy_seen == (dv ? 6 : 3) * maxn, dv ? "R5 verify cycles" : "R4 verify cycles",
            vfy_seen, (dv ? 6 : 3) * maxn);
        chk(pre_seen == (dv ? 3 * maxn : 0), dv ? "R5 pre-verify cycles" : "R4 pre-verify cycles",
            pre_seen, dv ? 3 * maxn : 0);
        chk(step_err == 0, "R6 step code per pulse", step_err, 0);
        chk(seq_err == 0, "R3 pump sequence", seq_err, 0);
        chk(bias_err == 0, "R8 bias in single-verify", bias_err, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) spd[i] = 8;
        model_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        // R1 reset state
        chk(!pgm_pump_en && !inh_pump_en && !vfy_pump_en, "R1 pumps idle", int'(pgm_pump_en), 0);
        chk(!busy && !done && !fail, "R1 flags idle", int'({busy, done, fail}), 0);
        chk(pulse_cnt == '0 && inhibit == '0, "R1 counters clear", int'(pulse_cnt), 0);

        // all L0 page: immediate done
        tgt_run = '0;
        run(1'b0, 1'b0);
        run(1'b1, 1'b0);

        // single cell at each level and speed, both modes
        for (int m = 0; m < 2; m++)
            for (int lv = 1; lv <= 3; lv++)
                for (int s = 6; s <= 12; s += 2) begin
                    tgt_run = '0;
                    tgt_run[1:0] = 2'(lv);
                    spd[0] = s;
                    run(m[0], 1'b0);
                end

        // mixed page
        tgt_run = {2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3, 2'd2, 2'd1};
        for (int i = 0; i < N; i++) spd[i] = 6 + 2 * (i % 6);
        run(1'b0, 1'b0);
        run(1'b1, 1'b0);

        // slow cell exhausts steps
        spd[2] = 4;
        run(1'b0, 1'b0);
        run(1'b1, 1'b0);

        // R12 configuration changes and start while busy
        for (int i = 0; i < N; i++) spd[i] = 6 + 2 * (i % 6);
        run(1'b0, 1'b1);
        run(1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule